// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up into a usable state before the memory controller starts normal traffic. A single start pulse makes it capture three configuration words: a bank configuration word, a timing configuration word and an optional mode override word. It then works out the mode-register data from the CAS latency and the data-bus width. It loads the controller's timing register with auto-refresh held off and issues the power-up command sequence on a command port with a one-cycle strobe. When the sequence is complete it loads the full timing word, which turns refresh on, and raises a sticky done flag.

All delays are counted in clock cycles. Both counts are derived from the `CLK_KHZ` parameter and rounded up. The power-up settle time is `POWER_CYC = ceil(200 * CLK_KHZ / 1000)` cycles, which is 200 µs. The gap between list commands is `GAP_CYC = max(2, ceil(80 * CLK_KHZ / 1000000))` cycles, which is at least 80 ns. The SDRAM array, the read/write datapath and the refresh timer are outside this block.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and after its release until a start, `cmdStrobe`, `timingWrite` and `initDone` are low, and `cmdWord` and `timingReg` read zero.
- R2: After a start, the first timing-register write comes before any command. It carries the captured timing word with its two-bit refresh field (bits `REFRESH_LSB+1:REFRESH_LSB`, default 13:12) cleared, and `timingWrite` is high for exactly one cycle per write.
- R3: The first command issued is a NOP with command word 0x01, and no mode bits are ORed into it. It appears exactly one cycle after the first timing write.
- R4: The second command strobe comes exactly `POWER_CYC` cycles after the NOP strobe.
- R5: After the NOP the list is one precharge (code 0x02), eight auto-refresh (code 0x03) and one mode-register-set (code 0x04), in that order. Each word is its code bitwise ORed with the mode data.
- R6: Successive list commands are exactly `GAP_CYC` cycles apart.
- R7: The computed mode data is 0x40 when the timing word's bits 2:0 equal 2, and 0x60 for any other value. It is halved (0x20 or 0x30) when bit 9 of the bank configuration word is set, which marks a 16-bit bus.
- R8: A nonzero mode override word is used as the mode data in place of the computed value.
- R9: `cmdStrobe` is high for exactly one cycle per command, giving 11 strobes per sequence.
- R10: One cycle after the last strobe, the unmodified timing word is written and `initDone` rises in the same cycle. `initDone` stays high until reset.
- R11: A start pulse while the sequence runs, or after it has finished, has no effect on strobes, timing writes or `initDone`.
- R12: The configuration inputs are sampled in the start cycle. Later changes to them do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begins initialization when the sequencer is idle |
| bankCfg | input | 32 | Bank configuration word; bit 9 set marks a 16-bit bus |
| timingCfg | input | 32 | Timing configuration word; bits 2:0 hold the CAS latency |
| modeOverride | input | 32 | Precomputed mode data; zero selects the computed value |
| cmdWord | output | 32 | Command word for the command register |
| cmdStrobe | output | 1 | One-cycle write strobe for `cmdWord` |
| timingReg | output | 32 | Value for the timing register |
| timingWrite | output | 1 | One-cycle write strobe for `timingReg` |
| initDone | output | 1 | Sticky initialization-complete flag |

## Verification
The bench covers every pairing of CAS latency and bus width. It also feeds CAS latency codes other than 2 and 3, which must select latency 3, and nonzero override words with low bits set. A design that decoded only the value 3 as latency 3, or that ignored the width bit, would put the wrong mode bits on all list words. The bench measures the power-up wait and the list gap to the exact cycle at a clock where the 80 ns gap needs rounding up. This catches an off-by-one counter or truncation instead of rounding. Start pulses arrive mid-sequence and after completion, and the configuration inputs change right after the start. A design that restarted, re-sampled its inputs, dropped refresh suppression or cleared done would show extra strobes, wrong words or wrong timing values.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] CODE_NOP = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CODE_PRE = 32'h0000_0002;
  localparam logic [WORD_W-1:0] CODE_REF = 32'h0000_0003;
  localparam logic [WORD_W-1:0] CODE_MRS = 32'h0000_0004;

  localparam logic [WORD_W-1:0] MODE_CL2_W32 = 32'h0000_0040;
  localparam logic [WORD_W-1:0] MODE_CL3_W32 = 32'h0000_0060;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_NOP,
    ST_WAIT,
    ST_RESTORE,
    ST_DONE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch configuration and mode data
    logic wrInit;    // write timing word with refresh suppressed
    logic wrFull;    // write unmodified timing word
    logic issueNop;  // send NOP and load the power-up wait
    logic issueList; // send current list entry and load the gap wait
  } seqStrb_t;

endpackage

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int POWER_CYC   = 10000,
  parameter int GAP_CYC     = 4,
  parameter int NUM_REF     = 8,
  parameter int REFRESH_LSB = 12,
  parameter int WIDTH_BIT   = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [WORD_W-1:0] bankCfg,
  input  logic [WORD_W-1:0] timingCfg,
  input  logic [WORD_W-1:0] modeOverride,
  output logic              cntZero,
  output logic              lastCmd,
  output logic [WORD_W-1:0] cmdWord,
  output logic              cmdStrobe,
  output logic [WORD_W-1:0] timingReg,
  output logic              timingWrite
);

  localparam int LIST_LEN = NUM_REF + 2;
  localparam int IDX_W    = $clog2(LIST_LEN + 1);
  localparam int CNT_MAX  = (POWER_CYC > GAP_CYC) ? POWER_CYC : GAP_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [WORD_W-1:0] REF_MASK = ~(WORD_W'(3) << REFRESH_LSB);
  localparam logic [CNT_W-1:0]  POWER_LOAD = CNT_W'(POWER_CYC - 1);
  localparam logic [CNT_W-1:0]  GAP_LOAD   = CNT_W'(GAP_CYC - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(LIST_LEN - 1);

  logic [WORD_W-1:0] timingQ;
  logic [WORD_W-1:0] modeQ;
  logic [WORD_W-1:0] modeCalc;
  logic [WORD_W-1:0] baseMode;
  logic [WORD_W-1:0] listCode;
  logic [CNT_W-1:0]  waitCnt;
  logic [IDX_W-1:0]  listIdx;

  // Mode data from CAS latency field and bus-width bit
  always_comb begin
    baseMode = (timingCfg[2:0] == 3'd2) ? MODE_CL2_W32 : MODE_CL3_W32;
    if (bankCfg[WIDTH_BIT]) begin
      baseMode = baseMode >> 1;
    end
    modeCalc = (modeOverride != '0) ? modeOverride : baseMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timingQ <= '0;
      modeQ   <= '0;
    end else if (strb.capture) begin
      timingQ <= timingCfg;
      modeQ   <= modeCalc;
    end
  end

  // Delay counter shared by the power-up wait and the list gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strb.issueNop) begin
      waitCnt <= POWER_LOAD;
    end else if (strb.issueList) begin
      waitCnt <= GAP_LOAD;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listIdx <= '0;
    end else if (strb.issueNop) begin
      listIdx <= '0;
    end else if (strb.issueList && (listIdx != LAST_IDX)) begin
      listIdx <= listIdx + 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);
  assign lastCmd = (listIdx == LAST_IDX);

  always_comb begin
    if (listIdx == '0) begin
      listCode = CODE_PRE;
    end else if (lastCmd) begin
      listCode = CODE_MRS;
    end else begin
      listCode = CODE_REF;
    end
  end

  // Registered command port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord   <= '0;
      cmdStrobe <= 1'b0;
    end else begin
      cmdStrobe <= strb.issueNop | strb.issueList;
      if (strb.issueNop) begin
        cmdWord <= CODE_NOP;
      end else if (strb.issueList) begin
        cmdWord <= listCode | modeQ;
      end
    end
  end

  // Registered timing port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timingReg   <= '0;
      timingWrite <= 1'b0;
    end else begin
      timingWrite <= strb.wrInit | strb.wrFull;
      if (strb.wrInit) begin
        timingReg <= timingQ & REF_MASK;
      end else if (strb.wrFull) begin
        timingReg <= timingQ;
      end
    end
  end

  // R4
  gap_respect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitCnt != '0) |-> !strb.issueList);

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);

  // R2
  timing_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingWrite |=> !timingWrite);

  // R3
  nop_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueNop |=> (cmdWord == CODE_NOP));

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     cntZero,
  input  logic     lastCmd,
  output seqStrb_t strb,
  output logic     initDone
);

  seqState_t state;
  seqState_t stateNxt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.capture = 1'b1;
          stateNxt     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strb.wrInit = 1'b1;
        stateNxt    = ST_NOP;
      end
      ST_NOP: begin
        strb.issueNop = 1'b1;
        stateNxt      = ST_WAIT;
      end
      ST_WAIT: begin
        if (cntZero) begin
          strb.issueList = 1'b1;
          if (lastCmd) begin
            stateNxt = ST_RESTORE;
          end
        end
      end
      ST_RESTORE: begin
        strb.wrFull = 1'b1;
        stateNxt    = ST_DONE;
      end
      ST_DONE: begin
        stateNxt = ST_DONE;
      end
      default: begin
        stateNxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  assign initDone = (state == ST_DONE);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_IDLE));

  // R10
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> !(strb.issueNop || strb.issueList || strb.wrInit));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_KHZ     = 50000,
  parameter int NUM_REF     = 8,
  parameter int REFRESH_LSB = 12,
  parameter int WIDTH_BIT   = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [31:0] bankCfg,
  input  logic [31:0] timingCfg,
  input  logic [31:0] modeOverride,
  output logic [31:0] cmdWord,
  output logic        cmdStrobe,
  output logic [31:0] timingReg,
  output logic        timingWrite,
  output logic        initDone
);

  localparam int POWER_CYC = (200 * CLK_KHZ + 999) / 1000;
  localparam int GAP_RAW   = (80 * CLK_KHZ + 999999) / 1000000;
  localparam int GAP_CYC   = (GAP_RAW < 2) ? 2 : GAP_RAW;

  seqStrb_t strb;
  logic     cntZero;
  logic     lastCmd;

  sdram_init_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .cntZero   (cntZero),
    .lastCmd   (lastCmd),
    .strb      (strb),
    .initDone  (initDone)
  );

  sdram_init_dp #(
    .POWER_CYC  (POWER_CYC),
    .GAP_CYC    (GAP_CYC),
    .NUM_REF    (NUM_REF),
    .REFRESH_LSB(REFRESH_LSB),
    .WIDTH_BIT  (WIDTH_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .bankCfg     (bankCfg),
    .timingCfg   (timingCfg),
    .modeOverride(modeOverride),
    .cntZero     (cntZero),
    .lastCmd     (lastCmd),
    .cmdWord     (cmdWord),
    .cmdStrobe   (cmdStrobe),
    .timingReg   (timingReg),
    .timingWrite (timingWrite)
  );

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int CLK_KHZ     = 33000;
  localparam int REFRESH_LSB = 12;
  localparam int POWER_EXP   = (200 * CLK_KHZ + 999) / 1000;
  localparam int GAP_RAW     = (80 * CLK_KHZ + 999999) / 1000000;
  localparam int GAP_EXP     = (GAP_RAW < 2) ? 2 : GAP_RAW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] bankCfg = '0;
  logic [31:0] timingCfg = '0;
  logic [31:0] modeOverride = '0;
  logic [31:0] cmdWord;
  logic        cmdStrobe;
  logic [31:0] timingReg;
  logic        timingWrite;
  logic        initDone;

  int nChk = 0;
  int nFail = 0;

  int cyc = 0;
  int nStrb = 0;
  int nTw = 0;
  int doneCyc = -1;
  int strbCyc [16];
  logic [31:0] strbWord [16];
  int twCyc [4];
  logic [31:0] twVal [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq #(.CLK_KHZ(CLK_KHZ), .REFRESH_LSB(REFRESH_LSB)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .bankCfg(bankCfg),
    .timingCfg(timingCfg), .modeOverride(modeOverride), .cmdWord(cmdWord),
    .cmdStrobe(cmdStrobe), .timingReg(timingReg), .timingWrite(timingWrite),
    .initDone(initDone)
  );

  // Monitor samples outputs at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN) begin
      if (cmdStrobe) begin
        if (nStrb < 16) begin
          strbCyc[nStrb]  = cyc;
          strbWord[nStrb] = cmdWord;
        end
        nStrb = nStrb + 1;
      end
      if (timingWrite) begin
        if (nTw < 4) begin
          twCyc[nTw] = cyc;
          twVal[nTw] = timingReg;
        end
        nTw = nTw + 1;
      end
      if (initDone && doneCyc < 0) doneCyc = cyc;
    end
  end

  function automatic logic [31:0] expMode(input logic [31:0] bank, timing, ovr);
    logic [31:0] m;
    if (ovr != 0) return ovr;
    m = (timing[2:0] == 3'd2) ? 32'h40 : 32'h60;
    if (bank[9]) m = m >> 1;
    return m;
  endfunction

  function automatic logic [31:0] expCode(input int i);
    if (i == 1) return 32'h2;
    if (i == 10) return 32'h4;
    return 32'h3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic runSeq(input logic [31:0] bank, input logic [31:0] timing,
                        input logic [31:0] ovr, input bit midStart, input string modeTag);
    logic [31:0] em;
    int guard;
    em = expMode(bank, timing, ovr);
    rstN = 1'b0;
    startPulse = 1'b0;
    bankCfg = $urandom;
    timingCfg = $urandom;
    modeOverride = $urandom;
    repeat (3) @(negedge clk);
    nStrb = 0; nTw = 0; doneCyc = -1;
    // R1 reset state
    chk("R1 cmdStrobe", {31'd0, cmdStrobe}, 32'd0);
    chk("R1 timingWrite", {31'd0, timingWrite}, 32'd0);
    chk("R1 initDone", {31'd0, initDone}, 32'd0);
    chk("R1 cmdWord", cmdWord, 32'd0);
    chk("R1 timingReg", timingReg, 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle strobes", nStrb + nTw, 32'd0);
    bankCfg = bank; timingCfg = timing; modeOverride = ovr;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    // R12 inputs change after the start cycle
    bankCfg = ~bank; timingCfg = timing ^ 32'h0000_3005; modeOverride = $urandom;
    if (midStart) begin
      repeat (50) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    guard = 0;
    while (!initDone && guard < POWER_EXP + 20 * GAP_EXP + 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (5) @(negedge clk);
    // R11 start after done
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (20) @(negedge clk);
    @(posedge clk);
    chk("R9/R11 strobe count", nStrb, 32'd11);
    chk("R2/R11 timing write count", nTw, 32'd2);
    chk("R10/R11 done held", {31'd0, initDone}, 32'd1);
    chk("R2/R12 init timing value", twVal[0], timing & ~(32'h3 << REFRESH_LSB));
    chk("R3 nop after init write", strbCyc[0] - twCyc[0], 32'd1);
    chk("R3 nop word", strbWord[0], 32'h1);
    chk("R4 power-up wait", strbCyc[1] - strbCyc[0], POWER_EXP);
    for (int i = 1; i < 11; i++) begin
      chk({"R5/", modeTag, " list word"}, strbWord[i], expCode(i) | em);
      if (i > 1) chk("R6 list gap", strbCyc[i] - strbCyc[i-1], GAP_EXP);
    end
    chk("R10/R12 full timing value", twVal[1], timing);
    chk("R10 full write after last", twCyc[1] - strbCyc[10], 32'd1);
    chk("R10 done rise cycle", doneCyc, twCyc[1]);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    // R7 directed corners: CL x width
    runSeq(32'h0000_0000, 32'h0000_3002, 32'h0, 1'b0, "R7");
    runSeq(32'h0000_0000, 32'h0000_1003, 32'h0, 1'b1, "R7");
    runSeq(32'h0000_0200, 32'h0000_2002, 32'h0, 1'b0, "R7");
    runSeq(32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'h0, 1'b1, "R7");
    // R7 latency codes other than 2 or 3
    runSeq(32'h0000_0200, 32'h0000_0000, 32'h0, 1'b0, "R7");
    runSeq(32'h0000_0000, 32'h0000_3007, 32'h0, 1'b0, "R7");
    // R8 override replaces computed mode
    runSeq(32'h0000_0200, 32'h0000_0002, 32'h0000_0180, 1'b1, "R8");
    runSeq(32'h0000_0000, 32'h0000_0003, 32'h0000_0005, 1'b0, "R8");
    for (int r = 0; r < 3; r++) begin
      logic [31:0] rb, rt, ro;
      rb = $urandom;
      rt = $urandom;
      ro = ($urandom % 3 == 0) ? $urandom : 32'h0;
      runSeq(rb, rt, ro, r[0], (ro != 0) ? "R8" : "R7");
    end
    finishRun();
  end

endmodule